// File: doc/BRIEF.md
# SPI Flash Menu-Driven Cycle Engine

This block is a register-programmed SPI master that runs exactly one flash cycle each time software writes a start command. Software does not write raw opcodes per transfer. It picks one of eight entries in an opcode menu, and a 2-bit kind per entry decides whether a 3-byte address follows the opcode and whether the data phase reads or writes. Data moves through a 64-byte buffer. Outgoing bytes are taken from the buffer, and incoming bytes are stored into it from byte 0 upward.

A cycle can be made atomic. In that case a separate one-byte prefix command, typically write-enable, is framed under its own chip select immediately before the main command, and no other access can come between the two. A lock input freezes the menu, kind and prefix registers, so that after lock only the commands already on the menu can be issued. Status flags report progress, completion and rejected requests.

Top module: `sfe_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, and the status and control registers read 0.
- R2: Control bit 0 starts a cycle. Bits 6:4 select menu entry k, and its opcode is sent first. Entries 0-3 live in word 5 and entries 4-7 in word 6, with entry k at bits 8*(k%4)+7:8*(k%4). The bus uses SPI mode 0: every byte goes MSB first, MOSI changes only while SCK is low, and MISO is sampled on the rising edge.
- R3: The kind register (word 3) holds 2 bits per entry, with entry k at bits 2k+1:2k. Code 0 reads without address, 1 writes without address, 2 reads with address and 3 writes with address. For codes 2 and 3, the low 24 bits of the address register (word 2) follow the opcode, most significant byte first. Bits 31:24 are never sent.
- R4: Control bit 15 enables the data phase, and bits 14:8 hold the byte count minus one. A write kind sends buffer bytes 0 to count-1 after the header. Buffer word 16+w holds byte 4w+j at bits 8j+7:8j.
- R5: A read kind stores the received bytes into the buffer starting at byte 0, in the order they arrive.
- R6: With control bit 2 set, the prefix register (word 4) is sent first as a one-byte frame. Chip select then stays high for at least 2 clocks before the main frame begins.
- R7: Status (word 1) has bit 0 in-progress, bit 1 done and bit 2 error. Done rises one clock after chip select goes high at the end of a cycle. Writing 1 clears done and error.
- R8: The start bit reads back as 0, and the rest of the control word is kept. In-progress is high from an accepted start until done is set. While a cycle runs, writes to control (including a new start) and to the buffer are ignored.
- R9: A start whose count field is 64 or more, or that selects a read kind with the data phase disabled, sets error and sends nothing.
- R10: While lock_i is high, writes to the menu, kind and prefix registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Freezes the menu, kind and prefix registers |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| spi_sck_o | output | 1 | SPI clock |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
Two functions can collide in the same cycle. The first collision is a new start or a buffer write arriving while an earlier cycle is still shifting. The bench launches a 64-byte write, then issues a second start and a buffer write before that write finishes. It judges the result by three things: exactly one frame appears on the bus, that frame carries the first opcode, and the buffer word reads back unchanged. The second collision is the completion flag being set on the same edge that the chip-select rising edge is seen. The bench records the clock of that rising edge and the clock of the first done reading, and requires them to differ by exactly one.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int REG_W  = 32;
    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_FLA  = 2;
    localparam int A_KIND = 3;
    localparam int A_PRE  = 4;
    localparam int A_MLO  = 5;
    localparam int A_MHI  = 6;

    typedef enum logic [1:0] {PH_PRE, PH_OP, PH_ADR, PH_DAT} phase_e;
    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP, S_FIN} seq_st_e;
endpackage

// File: rtl/sfe_shift.sv
module sfe_shift #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int DW = $clog2(HALF_DIV + 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.tx   = tx_i;
            s_d.bitn = '0;
            s_d.div  = '0;
            s_d.sck  = 1'b0;
        end else if (s_q.busy) begin
            if (s_q.div == DW'(HALF_DIV - 1)) begin
                s_d.div = '0;
                s_d.sck = ~s_q.sck;
                if (!s_q.sck) begin
                    s_d.rx = {s_q.rx[6:0], miso_i};
                end else if (s_q.bitn == 3'd7) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + 3'd1;
                    s_d.tx   = {s_q.tx[6:0], 1'b0};
                end
            end else begin
                s_d.div = s_q.div + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck_o  = s_q.sck;
    assign mosi_o = s_q.tx[7];
    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign rx_o   = s_q.rx;

    // R2: MOSI holds steady whenever SCK is high (mode 0)
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sck |-> $stable(mosi_o));
endmodule

// File: rtl/sfe_regs.sv
module sfe_regs
    import sfe_pkg::*;
#(
    parameter  int BUF_BYTES = 64,
    parameter  int MENU_N    = 8,
    parameter  int ADDR_W    = 5,
    localparam int LEN_W     = $clog2(BUF_BYTES) + 1,
    localparam int BI_W      = $clog2(BUF_BYTES),
    localparam int IDX_W     = $clog2(MENU_N)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            lock_i,
    input  logic                            wr_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [REG_W-1:0]                wdata_i,
    output logic [REG_W-1:0]                rdata_o,
    output logic                            go_o,
    output logic [7:0]                      opcode_o,
    output logic [1:0]                      kind_o,
    output logic [7:0]                      prefix_o,
    output logic                            atomic_o,
    output logic                            den_o,
    output logic [LEN_W-1:0]                len_o,
    output logic [23:0]                     fla_o,
    output logic [BUF_BYTES-1:0][7:0]       buf_o,
    input  logic                            cap_we_i,
    input  logic [BI_W-1:0]                 cap_idx_i,
    input  logic [7:0]                      cap_byte_i,
    input  logic                            done_i
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WW        = $clog2(BUF_WORDS);
    localparam int DATA_BASE = 1 << (ADDR_W - 1);

    typedef struct packed {
        logic [REG_W-1:0]        ctrl;
        logic [REG_W-1:0]        fla;
        logic [2*MENU_N-1:0]     kinds;
        logic [7:0]              prefix;
        logic [8*MENU_N-1:0]     menu;
        logic                    busy;
        logic                    done;
        logic                    err;
        logic [BUF_BYTES-1:0][7:0] dbuf;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] go_idx;
    logic [LEN_W-1:0] go_len;
    logic             go_den;
    logic [1:0]       go_kind;
    logic             go_bad;
    logic             ctrl_wr;
    logic             data_sel;
    logic [WW-1:0]    woff;

    always_comb begin
        go_idx   = wdata_i[4 +: IDX_W];
        go_len   = wdata_i[8 +: LEN_W];
        go_den   = wdata_i[8 + LEN_W];
        go_kind  = r_q.kinds[{go_idx, 1'b0} +: 2];
        go_bad   = (go_len >= LEN_W'(BUF_BYTES)) || (!go_den && !go_kind[0]);
        ctrl_wr  = wr_i && (addr_i == ADDR_W'(A_CTRL));
        go_o     = ctrl_wr && wdata_i[0] && !r_q.busy && !go_bad;
        data_sel = addr_i[ADDR_W-1];
        woff     = addr_i[WW-1:0];
    end

    assign opcode_o = r_q.menu[{go_idx, 3'b000} +: 8];
    assign kind_o   = go_kind;
    assign prefix_o = r_q.prefix;
    assign atomic_o = wdata_i[2];
    assign den_o    = go_den;
    assign len_o    = go_len;
    assign fla_o    = r_q.fla[23:0];
    assign buf_o    = r_q.dbuf;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (data_sel) begin
                if (!r_q.busy) begin
                    for (int b = 0; b < 4; b++) begin
                        r_d.dbuf[{woff, 2'(b)}] = wdata_i[8*b +: 8];
                    end
                end
            end else begin
                case (int'(addr_i))
                    A_CTRL: begin
                        if (!r_q.busy) begin
                            r_d.ctrl = {wdata_i[REG_W-1:1], 1'b0};
                            if (wdata_i[0]) begin
                                if (go_bad) r_d.err  = 1'b1;
                                else        r_d.busy = 1'b1;
                            end
                        end
                    end
                    A_STAT: begin
                        if (wdata_i[1]) r_d.done = 1'b0;
                        if (wdata_i[2]) r_d.err  = 1'b0;
                    end
                    A_FLA:  r_d.fla = wdata_i;
                    A_KIND: if (!lock_i) r_d.kinds = wdata_i[2*MENU_N-1:0];
                    A_PRE:  if (!lock_i) r_d.prefix = wdata_i[7:0];
                    A_MLO:  if (!lock_i) r_d.menu[31:0] = wdata_i;
                    A_MHI:  if (!lock_i) r_d.menu[8*MENU_N-1:32] = wdata_i[8*MENU_N-33:0];
                    default: ;
                endcase
            end
        end
        if (cap_we_i) r_d.dbuf[cap_idx_i] = cap_byte_i;
        if (done_i) begin
            r_d.busy = 1'b0;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (data_sel) begin
            for (int b = 0; b < 4; b++) begin
                rdata_o[8*b +: 8] = r_q.dbuf[{woff, 2'(b)}];
            end
        end else begin
            case (int'(addr_i))
                A_CTRL: rdata_o = r_q.ctrl;
                A_STAT: rdata_o = {29'd0, r_q.err, r_q.done, r_q.busy};
                A_FLA:  rdata_o = r_q.fla;
                A_KIND: rdata_o[2*MENU_N-1:0] = r_q.kinds;
                A_PRE:  rdata_o[7:0] = r_q.prefix;
                A_MLO:  rdata_o = r_q.menu[31:0];
                A_MHI:  rdata_o[8*MENU_N-33:0] = r_q.menu[8*MENU_N-1:32];
                default: ;
            endcase
        end
    end

    // R8: completion only arrives for a cycle that was accepted
    assert_done_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> r_q.busy);
    // R8: an accepted start leaves the engine in progress
    assert_go_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> r_q.busy);
    // R10: locked prefix register does not move on a write
    assert_lock_prefix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && wr_i && addr_i == ADDR_W'(A_PRE)) |=> $stable(r_q.prefix));
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
    import sfe_pkg::*;
#(
    parameter  int BUF_BYTES = 64,
    parameter  int GAP_CLKS  = 2,
    localparam int LEN_W     = $clog2(BUF_BYTES) + 1,
    localparam int BI_W      = $clog2(BUF_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go_i,
    input  logic [7:0]                opcode_i,
    input  logic [1:0]                kind_i,
    input  logic [7:0]                prefix_i,
    input  logic                      atomic_i,
    input  logic                      den_i,
    input  logic [LEN_W-1:0]          len_i,
    input  logic [23:0]               fla_i,
    input  logic [BUF_BYTES-1:0][7:0] buf_i,
    output logic                      sh_start_o,
    output logic [7:0]                sh_tx_o,
    input  logic                      sh_busy_i,
    input  logic                      sh_done_i,
    input  logic [7:0]                sh_rx_i,
    output logic                      cs_n_o,
    output logic                      cap_we_o,
    output logic [BI_W-1:0]           cap_idx_o,
    output logic [7:0]                cap_byte_o,
    output logic                      done_o
);
    localparam int GW = $clog2(GAP_CLKS + 1);

    typedef struct packed {
        seq_st_e          st;
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [GW-1:0]    gap;
        logic             cs_n;
        logic [7:0]       op;
        logic [7:0]       pre;
        logic [1:0]       kind;
        logic             den;
        logic [LEN_W-1:0] len;
        logic [23:0]      fla;
    } seq_t;

    seq_t s_d, s_q;
    logic [1:0] asel;
    logic       finish;

    always_comb begin
        asel = 2'd2 - s_q.cnt[1:0];
        unique case (s_q.ph)
            PH_PRE:  sh_tx_o = s_q.pre;
            PH_OP:   sh_tx_o = s_q.op;
            PH_ADR:  sh_tx_o = s_q.fla[{asel, 3'b000} +: 8];
            default: sh_tx_o = s_q.kind[0] ? buf_i[s_q.cnt[BI_W-1:0]] : 8'h00;
        endcase
    end

    assign cap_idx_o  = s_q.cnt[BI_W-1:0];
    assign cap_byte_o = sh_rx_i;
    assign cs_n_o     = s_q.cs_n;

    always_comb begin
        s_d        = s_q;
        sh_start_o = 1'b0;
        cap_we_o   = 1'b0;
        done_o     = 1'b0;
        finish     = 1'b0;
        unique case (s_q.st)
            S_IDLE: begin
                if (go_i) begin
                    s_d.op   = opcode_i;
                    s_d.pre  = prefix_i;
                    s_d.kind = kind_i;
                    s_d.den  = den_i;
                    s_d.len  = len_i;
                    s_d.fla  = fla_i;
                    s_d.cnt  = '0;
                    s_d.ph   = atomic_i ? PH_PRE : PH_OP;
                    s_d.st   = S_LOAD;
                end
            end
            S_LOAD: begin
                sh_start_o = 1'b1;
                s_d.cs_n   = 1'b0;
                s_d.st     = S_SHIFT;
            end
            S_SHIFT: begin
                if (sh_done_i) begin
                    s_d.st = S_LOAD;
                    unique case (s_q.ph)
                        PH_PRE: begin
                            s_d.cs_n = 1'b1;
                            s_d.gap  = '0;
                            s_d.ph   = PH_OP;
                            s_d.st   = S_GAP;
                        end
                        PH_OP: begin
                            s_d.cnt = '0;
                            if (s_q.kind[1])  s_d.ph = PH_ADR;
                            else if (s_q.den) s_d.ph = PH_DAT;
                            else              finish = 1'b1;
                        end
                        PH_ADR: begin
                            if (s_q.cnt == LEN_W'(2)) begin
                                s_d.cnt = '0;
                                if (s_q.den) s_d.ph = PH_DAT;
                                else         finish = 1'b1;
                            end else begin
                                s_d.cnt = s_q.cnt + LEN_W'(1);
                            end
                        end
                        default: begin
                            cap_we_o = !s_q.kind[0];
                            if (s_q.cnt == s_q.len) finish = 1'b1;
                            else s_d.cnt = s_q.cnt + LEN_W'(1);
                        end
                    endcase
                    if (finish) begin
                        s_d.cs_n = 1'b1;
                        s_d.st   = S_FIN;
                    end
                end
            end
            S_GAP: begin
                s_d.gap = s_q.gap + GW'(1);
                if (s_q.gap == GW'(GAP_CLKS - 1)) s_d.st = S_LOAD;
            end
            default: begin
                done_o = 1'b1;
                s_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= S_IDLE;
            s_q.ph   <= PH_OP;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: the serial clock only runs inside a chip-select frame
    assert_sck_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy_i |-> !s_q.cs_n);
    // R8: a start reaches the sequencer only when it is idle
    assert_go_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (s_q.st == S_IDLE));
endmodule

// File: rtl/sfe_engine.sv
module sfe_engine
    import sfe_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int MENU_N    = 8,
    parameter int ADDR_W    = 5,
    parameter int HALF_DIV  = 2,
    parameter int GAP_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              spi_sck_o,
    output logic              spi_cs_n_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);
    localparam int LEN_W = $clog2(BUF_BYTES) + 1;
    localparam int BI_W  = $clog2(BUF_BYTES);

    logic                      go;
    logic [7:0]                opcode, prefix, sh_tx, sh_rx, cap_byte;
    logic [1:0]                kind;
    logic                      atomic, den;
    logic [LEN_W-1:0]          len;
    logic [23:0]               fla;
    logic [BUF_BYTES-1:0][7:0] dbuf;
    logic                      cap_we, seq_done;
    logic [BI_W-1:0]           cap_idx;
    logic                      sh_start, sh_busy, sh_done;

    sfe_regs #(.BUF_BYTES(BUF_BYTES), .MENU_N(MENU_N), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
        .go_o(go), .opcode_o(opcode), .kind_o(kind), .prefix_o(prefix),
        .atomic_o(atomic), .den_o(den), .len_o(len), .fla_o(fla), .buf_o(dbuf),
        .cap_we_i(cap_we), .cap_idx_i(cap_idx), .cap_byte_i(cap_byte), .done_i(seq_done)
    );

    sfe_seq #(.BUF_BYTES(BUF_BYTES), .GAP_CLKS(GAP_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(go), .opcode_i(opcode), .kind_i(kind),
        .prefix_i(prefix), .atomic_i(atomic), .den_i(den), .len_i(len), .fla_i(fla),
        .buf_i(dbuf), .sh_start_o(sh_start), .sh_tx_o(sh_tx), .sh_busy_i(sh_busy),
        .sh_done_i(sh_done), .sh_rx_i(sh_rx), .cs_n_o(spi_cs_n_o),
        .cap_we_o(cap_we), .cap_idx_o(cap_idx), .cap_byte_o(cap_byte), .done_o(seq_done)
    );

    sfe_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(sh_start), .tx_i(sh_tx), .miso_i(spi_miso_i),
        .sck_o(spi_sck_o), .mosi_o(spi_mosi_o), .busy_o(sh_busy), .done_o(sh_done), .rx_o(sh_rx)
    );
endmodule

// File: tb/sfe_engine_test.sv
`timescale 1ns/1ps
module sfe_engine_test;
    import sfe_pkg::*;

    typedef struct packed {
        logic [2:0]  idx;
        logic        atomic;
        logic        den;
        logic [6:0]  len;
        logic [31:0] fla;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 1'b0, 1'b1, 7'd3,  32'hAB123456},
        '{3'd3, 1'b1, 1'b1, 7'd0,  32'h00FEDCBA},
        '{3'd1, 1'b0, 1'b0, 7'd0,  32'h0},
        '{3'd0, 1'b0, 1'b1, 7'd1,  32'h0},
        '{3'd7, 1'b0, 1'b1, 7'd63, 32'h55000102},
        '{3'd6, 1'b0, 1'b1, 7'd63, 32'h00800001},
        '{3'd5, 1'b1, 1'b1, 7'd2,  32'h0}
    };

    logic clk = 0, rst_n = 0, lock = 0, wr = 0, miso = 0;
    logic [4:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic sck, cs_n, mosi;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    sfe_engine uut (
        .clk(clk), .rst_n(rst_n), .lock_i(lock), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spi_sck_o(sck), .spi_cs_n_o(cs_n),
        .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    function automatic logic [7:0] resp(int b);
        return 8'h5A ^ 8'(b * 13);
    endfunction
    function automatic logic [7:0] pat(int i);
        return 8'hC0 ^ 8'(i * 3);
    endfunction
    function automatic logic [7:0] opc(int k);
        return 8'h10 + 8'(k * 17);
    endfunction

    // flash model and frame log
    int cyc = 0, fcount = 0, hi_cnt = 0, bitpos = 0, cs_rise_cyc = 0;
    logic cs_prev = 1, sck_prev = 0;
    logic [7:0] shreg = 0;
    logic [7:0] flog [8][80];
    int nb [8];
    int gaps [8];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        logic [7:0] r;
        int cur;
        if (!cs_n && cs_prev) begin
            gaps[fcount % 8] = hi_cnt;
            nb[fcount % 8] = 0;
            hi_cnt = 0;
            bitpos = 0;
            fcount++;
            r = resp(0);
            miso = r[7];
        end else if (!cs_n) begin
            cur = (fcount - 1) % 8;
            if (sck && !sck_prev) begin
                shreg = {shreg[6:0], mosi};
                bitpos++;
                if (bitpos % 8 == 0 && nb[cur] < 80) begin
                    flog[cur][nb[cur]] = shreg;
                    nb[cur]++;
                end
            end
            if (!sck && sck_prev) begin
                r = resp(bitpos / 8);
                miso = r[7 - bitpos % 8];
            end
        end
        if (cs_n) hi_cnt++;
        if (cs_n && !cs_prev) cs_rise_cyc = cyc;
        cs_prev = cs_n;
        sck_prev = sck;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 5'(a); wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        @(negedge clk);
        addr = 5'(a);
        #0.5;
        v = rdata;
    endtask

    task automatic wait_end(output logic [31:0] s, output int dc);
        s = 0; dc = 0;
        for (int t = 0; t < 20000; t++) begin
            rd_reg(A_STAT, s);
            if (s[1] || s[2]) begin dc = cyc; break; end
        end
    endtask

    task automatic load_buf();
        for (int w = 0; w < 16; w++)
            wr_reg(16 + w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    endtask

    function automatic logic [31:0] cword(vec_t v);
        return 32'd1 | (32'(v.atomic) << 2) | (32'(v.idx) << 4) | (32'(v.len) << 8) | (32'(v.den) << 15);
    endfunction

    task automatic run_vec(input vec_t v);
        logic [31:0] s, w;
        int f0, dc, kind, hdr, ms, na;
        f0 = fcount;
        kind = int'(v.idx[1:0]);
        hdr = 1 + ((kind >= 2) ? 3 : 0);
        na = v.atomic ? 1 : 0;
        wr_reg(A_CTRL, cword(v));
        wait_end(s, dc);
        chk(s[2:0] == 3'b010, "R7 done set without error", s, 2);
        chk(dc - cs_rise_cyc == 1, "R7 done one clock after cs high", dc - cs_rise_cyc, 1);
        chk(fcount - f0 == 1 + na, "R6 frame count", fcount - f0, 1 + na);
        if (v.atomic) begin
            chk(nb[f0 % 8] == 1, "R6 prefix frame length", nb[f0 % 8], 1);
            chk(flog[f0 % 8][0] == 8'h06, "R6 prefix byte", flog[f0 % 8][0], 8'h06);
            chk(gaps[(f0 + 1) % 8] >= 2, "R6 cs gap", gaps[(f0 + 1) % 8], 2);
        end
        ms = (f0 + na) % 8;
        chk(nb[ms] == hdr + (v.den ? int'(v.len) + 1 : 0), "R4 frame byte count",
            nb[ms], hdr + (v.den ? int'(v.len) + 1 : 0));
        chk(flog[ms][0] == opc(v.idx), "R2 opcode from menu", flog[ms][0], opc(v.idx));
        if (kind >= 2)
            for (int j = 0; j < 3; j++)
                chk(flog[ms][1+j] == v.fla[23-8*j -: 8], "R3 address byte", flog[ms][1+j], v.fla[23-8*j -: 8]);
        if (v.den && kind[0])
            for (int i = 0; i <= int'(v.len); i++)
                chk(flog[ms][hdr+i] == pat(i), "R4 write data byte", flog[ms][hdr+i], pat(i));
        if (v.den && !kind[0])
            for (int i = 0; i <= int'(v.len); i++) begin
                rd_reg(16 + i/4, w);
                chk(w[8*(i%4) +: 8] == resp(hdr+i), "R5 captured byte", w[8*(i%4) +: 8], resp(hdr+i));
            end
        wr_reg(A_STAT, 32'h6);
        rd_reg(A_STAT, s);
        chk(s == 0, "R7 write-one clear", s, 0);
    endtask

    initial begin
        #(150000 * 5);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, s;
        int f0, dc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_reg(A_STAT, v);
        chk(v == 0, "R1 status after reset", v, 0);
        rd_reg(A_CTRL, v);
        chk(v == 0, "R1 control after reset", v, 0);
        chk(cs_n == 1 && sck == 0, "R1 pins idle", {cs_n, sck}, 2'b10);

        wr_reg(A_MLO, {opc(3), opc(2), opc(1), opc(0)});
        wr_reg(A_MHI, {opc(7), opc(6), opc(5), opc(4)});
        wr_reg(A_KIND, 32'hE4E4);
        wr_reg(A_PRE, 32'h06);

        for (int i = 0; i < NV; i++) begin
            load_buf();
            wr_reg(A_FLA, VECS[i].fla);
            run_vec(VECS[i]);
        end

        // R9 rejected requests
        f0 = fcount;
        wr_reg(A_CTRL, 32'd1 | (32'd3 << 4) | (32'd64 << 8) | (32'd1 << 15));
        rd_reg(A_STAT, s);
        chk(s[2:0] == 3'b100, "R9 count overflow sets error", s, 4);
        wr_reg(A_STAT, 32'h4);
        wr_reg(A_CTRL, 32'd1 | (32'd4 << 4));
        rd_reg(A_STAT, s);
        chk(s[2:0] == 3'b100, "R9 read kind without data sets error", s, 4);
        repeat (40) @(negedge clk);
        chk(fcount == f0, "R9 nothing sent", fcount - f0, 0);
        wr_reg(A_STAT, 32'h4);

        // R8 collisions with a running cycle
        load_buf();
        f0 = fcount;
        wr_reg(A_CTRL, cword(VECS[4]));
        repeat (10) @(negedge clk);
        rd_reg(A_STAT, s);
        chk(s[0] == 1, "R8 in progress while running", s[0], 1);
        rd_reg(A_CTRL, v);
        chk(v == (cword(VECS[4]) & ~32'd1), "R8 start bit self-clears", v, cword(VECS[4]) & ~32'd1);
        wr_reg(A_CTRL, 32'd1 | (32'd1 << 4));
        wr_reg(16, 32'hDEADBEEF);
        wait_end(s, dc);
        chk(s[2:0] == 3'b010, "R8 first cycle completes cleanly", s, 2);
        chk(fcount - f0 == 1, "R8 second start ignored", fcount - f0, 1);
        chk(flog[f0 % 8][0] == opc(7), "R8 frame carries first opcode", flog[f0 % 8][0], opc(7));
        rd_reg(16, v);
        chk(v == {pat(3), pat(2), pat(1), pat(0)}, "R8 buffer write ignored while busy", v,
            {pat(3), pat(2), pat(1), pat(0)});
        wr_reg(A_STAT, 32'h2);
        repeat (20) @(negedge clk);
        chk(fcount - f0 == 1, "R8 no late cycle", fcount - f0, 1);

        // R10 lock
        lock = 1;
        wr_reg(A_PRE, 32'h99);
        wr_reg(A_MLO, 32'h0);
        wr_reg(A_KIND, 32'h0);
        rd_reg(A_PRE, v);
        chk(v == 32'h06, "R10 prefix frozen", v, 32'h06);
        rd_reg(A_MLO, v);
        chk(v == {opc(3), opc(2), opc(1), opc(0)}, "R10 menu frozen", v, {opc(3), opc(2), opc(1), opc(0)});
        rd_reg(A_KIND, v);
        chk(v == 32'hE4E4, "R10 kinds frozen", v, 32'hE4E4);
        load_buf();
        run_vec(VECS[6]);
        lock = 0;
        wr_reg(A_PRE, 32'h50);
        rd_reg(A_PRE, v);
        chk(v == 32'h50, "R10 prefix writable when unlocked", v, 32'h50);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule